// File: doc/BRIEF.md
# Four-Point Shift-Twiddle Number-Theoretic Transform Kernel

This kernel computes a four-point number-theoretic transform over the prime field with modulus p = 2^64 - 2^32 + 1. Four reduced 64-bit residues enter together and four reduced 64-bit transform values leave together. The principal fourth root of unity in this field is w = 2^48. Every twiddle product inside the kernel is therefore a fixed modular left shift, and since w^2 = 2^96 is congruent to -1, the remaining twiddle becomes the sign flip that a butterfly's subtract leg already provides. The kernel has no multiplier, no twiddle port and no direction select.

Internally two layers of two-point butterflies do the work. The first layer pairs the inputs (s0,s2) and (s1,s3) into four intermediates. The second layer combines those intermediates, and its only non-trivial twiddle is a shift by 48 bits on one leg. A parameter places an output register after the second layer, giving a one-cycle pipeline that accepts a new set every cycle. With the parameter cleared, the kernel is purely combinational and the valid flag passes straight through. A larger transform uses this kernel as its radix-4 engine and supplies the memory, the inter-stage twiddles and any inverse scaling around it.

Top module: `ntt4_kernel`

## Requirements
- R1: f0 equals (s0 + s1 + s2 + s3) mod p.
- R2: f1 equals (s0 + w*s1 - s2 - w*s3) mod p, with w = 2^48.
- R3: f2 equals (s0 - s1 + s2 - s3) mod p.
- R4: f3 equals (s0 - w*s1 - s2 + w*s3) mod p, with w = 2^48.
- R5: Every output is strictly below p whenever all four inputs are below p, including when every input equals p - 1.
- R6: With the output register enabled (the default), results and out_valid appear exactly one clock after the set is presented with in_valid high, and sets may arrive on consecutive cycles.
- R7: While rst_n is low, out_valid is 0 and f0..f3 are 0.
- R8: In a cycle where in_valid is low, out_valid is 0 on the next clock and f0..f3 keep their previous values, whatever s0..s3 carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks s0..s3 as a set to transform |
| s0 | input | 64 | Time-domain sample 0, below p |
| s1 | input | 64 | Time-domain sample 1, below p |
| s2 | input | 64 | Time-domain sample 2, below p |
| s3 | input | 64 | Time-domain sample 3, below p |
| out_valid | output | 1 | Marks f0..f3 as a fresh result |
| f0 | output | 64 | Transform value 0 |
| f1 | output | 64 | Transform value 1 |
| f2 | output | 64 | Transform value 2 |
| f3 | output | 64 | Transform value 3 |

## Verification
The hardest case to reach is the shift-and-fold reduction overflowing into its final correction. That only happens when the shifted operand has large upper halves and a subtract leg wraps at the same time. The directed sets therefore include every input at p - 1, alternating extremes of p - 1 and 0, and single impulses in the shifted lanes, together with random full-range residues. Back-to-back streaming and idle cycles that carry new input values confirm the pipeline timing and the hold behaviour.

// File: rtl/ntt4_pkg.sv
package ntt4_pkg;

    localparam int unsigned WORD_W     = 64;
    localparam int unsigned LANES      = 4;
    localparam int unsigned HALF       = LANES / 2;
    localparam int unsigned ROOT_SHIFT = 48;          // w = 2^48, fourth root of unity
    localparam int unsigned WIDE_W     = 2 * WORD_W;
    localparam int unsigned FOLD_W     = WORD_W + 3;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t MODP = 64'hFFFF_FFFF_0000_0001;

    // reduce any 128-bit value modulo p using 2^64 = 2^32 - 1 and 2^96 = -1
    function automatic word_t fold_wide(input logic [WIDE_W-1:0] v);
        logic [FOLD_W-1:0] q3, q2, q1, q0, t;
        logic [WORD_W+1:0] u;
        logic [2:0]        hi;
        q3 = {35'd0, v[127:96]};
        q2 = {35'd0, v[95:64]};
        q1 = {35'd0, v[63:32]};
        q0 = {35'd0, v[31:0]};
        t  = ((q2 + q1) << 32) + q0 + {2'b00, MODP, 1'b0} - q3 - q2;
        hi = t[FOLD_W-1:WORD_W];
        u  = {2'b00, t[WORD_W-1:0]} + ({63'd0, hi} << 32) - {63'd0, hi};
        if (u >= {2'b00, MODP})
            u = u - {2'b00, MODP};
        return u[WORD_W-1:0];
    endfunction

    function automatic word_t mod_add(input word_t x, input word_t y);
        logic [WORD_W:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (s >= {1'b0, MODP})
            s = s - {1'b0, MODP};
        return s[WORD_W-1:0];
    endfunction

    function automatic word_t mod_sub(input word_t x, input word_t y);
        word_t r;
        if (x >= y)
            r = x - y;
        else
            r = x + (MODP - y);
        return r;
    endfunction

endpackage

// File: rtl/ntt4_shift.sv
module ntt4_shift
    import ntt4_pkg::*;
#(
    parameter int unsigned SHIFT = 0
) (
    input  word_t op_in,
    output word_t op_out
);
    generate
        if (SHIFT == 0) begin : g_pass
            assign op_out = op_in;
        end else begin : g_fold
            logic [WIDE_W-1:0] widened;
            assign widened = {{WORD_W{1'b0}}, op_in} << SHIFT;
            assign op_out  = fold_wide(widened);
        end
    endgenerate
endmodule

// File: rtl/ntt4_bfly.sv
module ntt4_bfly
    import ntt4_pkg::*;
#(
    parameter int unsigned TW_SHIFT = 0
) (
    input  word_t lo_in,
    input  word_t hi_in,
    output word_t sum_out,
    output word_t dif_out
);
    word_t twisted;

    ntt4_shift #(.SHIFT(TW_SHIFT)) u_tw (
        .op_in  (hi_in),
        .op_out (twisted)
    );

    always_comb begin
        sum_out = mod_add(lo_in, twisted);
        dif_out = mod_sub(lo_in, twisted);
    end
endmodule

// File: rtl/ntt4_kernel.sv
module ntt4_kernel
    import ntt4_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] s0,
    input  logic [63:0] s1,
    input  logic [63:0] s2,
    input  logic [63:0] s3,
    output logic        out_valid,
    output logic [63:0] f0,
    output logic [63:0] f1,
    output logic [63:0] f2,
    output logic [63:0] f3
);
    logic [LANES-1:0][WORD_W-1:0] stage_in;
    logic [LANES-1:0][WORD_W-1:0] mid;
    logic [LANES-1:0][WORD_W-1:0] res;
    logic [LANES-1:0][WORD_W-1:0] held;
    logic                         valid_q;

    assign stage_in = {s3, s2, s1, s0};

    // first layer: (s0,s2) and (s1,s3), unit twiddle
    for (genvar j = 0; j < HALF; j++) begin : g_layer1
        ntt4_bfly #(.TW_SHIFT(0)) u_bf (
            .lo_in   (stage_in[j]),
            .hi_in   (stage_in[j+HALF]),
            .sum_out (mid[2*j]),
            .dif_out (mid[2*j+1])
        );
    end

    // second layer: twiddle 1 on even pair, w = 2^48 on odd pair
    for (genvar j = 0; j < HALF; j++) begin : g_layer2
        ntt4_bfly #(.TW_SHIFT(j * ROOT_SHIFT)) u_bf (
            .lo_in   (mid[j]),
            .hi_in   (mid[j+HALF]),
            .sum_out (res[j]),
            .dif_out (res[j+HALF])
        );
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    held    <= '0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid)
                        held <= res;
                end
            end

            assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_idle_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(f0) && $stable(f1) && $stable(f2) && $stable(f3)));
            assert_out_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (f0 < MODP && f1 < MODP && f2 < MODP && f3 < MODP));
            assert_mid_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (mid[0] < MODP && mid[1] < MODP && mid[2] < MODP && mid[3] < MODP));
            assert_dc_bin_R1: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> f0 == mod_add(mod_add($past(s0), $past(s1)),
                                           mod_add($past(s2), $past(s3))));
            assert_alt_bin_R3: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> f2 == mod_sub(mod_add($past(s0), $past(s2)),
                                           mod_add($past(s1), $past(s3))));
        end else begin : g_comb
            assign valid_q = in_valid;
            assign held    = res;
        end
    endgenerate

    assign out_valid = valid_q;
    assign f0        = held[0];
    assign f1        = held[1];
    assign f2        = held[2];
    assign f3        = held[3];
endmodule

// File: tb/tb_ntt4_kernel.sv
module tb_ntt4_kernel;
    localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0;
    logic        out_valid;
    logic [63:0] f0, f1, f2, f3;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ntt4_kernel dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .s0(s0), .s1(s1), .s2(s2), .s3(s3),
        .out_valid(out_valid), .f0(f0), .f1(f1), .f2(f2), .f3(f3)
    );

    function automatic logic [63:0] m_add(input logic [63:0] a, input logic [63:0] b);
        logic [65:0] t;
        t = {2'b00, a} + {2'b00, b};
        return 64'(t % {2'b00, P});
    endfunction

    function automatic logic [63:0] m_sub(input logic [63:0] a, input logic [63:0] b);
        return m_add(a, (b == 64'd0) ? 64'd0 : P - b);
    endfunction

    function automatic logic [63:0] m_w(input logic [63:0] a);
        logic [127:0] t;
        t = {64'd0, a} << 48;
        return 64'(t % {64'd0, P});
    endfunction

    logic [63:0] e0, e1, e2, e3;

    task automatic expect_of(input logic [63:0] a0, a1, a2, a3);
        e0 = m_add(m_add(a0, a1), m_add(a2, a3));
        e2 = m_sub(m_add(a0, a2), m_add(a1, a3));
        e1 = m_sub(m_add(a0, m_w(a1)), m_add(a2, m_w(a3)));
        e3 = m_sub(m_add(a0, m_w(a3)), m_add(a2, m_w(a1)));
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({"R1 ", tag}, f0, e0);
        chk({"R2 ", tag}, f1, e1);
        chk({"R3 ", tag}, f2, e2);
        chk({"R4 ", tag}, f3, e3);
        chk({"R5 ", tag}, 64'(f0 < P && f1 < P && f2 < P && f3 < P), 64'd1);
        chk({"R6 ", tag}, 64'(out_valid), 64'd1);
    endtask

    // drive one set, wait one clock, check
    task automatic t_single(input string tag, input logic [63:0] a0, a1, a2, a3);
        @(negedge clk);
        s0 = a0; s1 = a1; s2 = a2; s3 = a3; in_valid = 1'b1;
        expect_of(a0, a1, a2, a3);
        @(negedge clk);
        in_valid = 1'b0;
        chk_all(tag);
    endtask

    task automatic t_reset();
        #1;
        chk("R7 valid in reset", 64'(out_valid), 64'd0);
        chk("R7 f0 in reset", f0, 64'd0);
        chk("R7 f3 in reset", f3, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_stream();
        logic [63:0] q0, q1, q2, q3;
        logic        have = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (have) chk_all("stream");
            q0 = {$urandom, $urandom} % P; q1 = {$urandom, $urandom} % P;
            q2 = {$urandom, $urandom} % P; q3 = {$urandom, $urandom} % P;
            s0 = q0; s1 = q1; s2 = q2; s3 = q3; in_valid = 1'b1;
            expect_of(q0, q1, q2, q3);
            have = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk_all("stream last");
    endtask

    task automatic t_hold();
        t_single("hold base", 64'd11, 64'd22, 64'd33, 64'd44);
        for (int k = 0; k < 3; k++) begin
            s0 = P - 1; s1 = 64'd7; s2 = 64'd0; s3 = 64'h1234;
            in_valid = 1'b0;
            @(negedge clk);
            chk("R8 valid low", 64'(out_valid), 64'd0);
            chk("R8 f0 held", f0, e0);
            chk("R8 f1 held", f1, e1);
            chk("R8 f2 held", f2, e2);
            chk("R8 f3 held", f3, e3);
        end
    endtask

    initial begin
        t_reset();
        t_single("zeros", 64'd0, 64'd0, 64'd0, 64'd0);
        t_single("impulse0", 64'd1, 64'd0, 64'd0, 64'd0);
        t_single("impulse1", 64'd0, 64'd1, 64'd0, 64'd0);
        t_single("impulse3", 64'd0, 64'd0, 64'd0, 64'd1);
        t_single("all max", P - 1, P - 1, P - 1, P - 1);
        t_single("alt max", P - 1, 64'd0, P - 1, 64'd0);
        t_single("alt max b", 64'd0, P - 1, 64'd0, P - 1);
        t_single("high halves", 64'hFFFF_FFFE_FFFF_FFFF, 64'hFFFF_0000_FFFF_0000,
                 64'd5, 64'hFFFF_FFFF_0000_0000);
        for (int k = 0; k < 16; k++)
            t_single("random", {$urandom, $urandom} % P, {$urandom, $urandom} % P,
                     {$urandom, $urandom} % P, {$urandom, $urandom} % P);
        t_stream();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule